// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter in a small microcontroller. Software selects one of eight analog channels and a conversion speed through a byte-wide control/status register, then starts a conversion by writing 0 to the completion flag. The controller drives the channel number to an external multiplexer and a 10-bit trial code to an external resistor-ladder DAC. It reads a single comparator bit back and resolves the result one bit at a time, most significant bit first.

A conversion always lasts 61 conversion-clock ticks. The conversion clock is either the system clock itself or the system clock divided by two, so a conversion takes 61 or 122 system-clock cycles. The 61 ticks are split into 8 sampling ticks, 5 settling ticks per bit and 3 latching ticks. When a conversion finishes, the result register is loaded, the completion flag returns to 1 and an interrupt request is raised. The request stays set until a clear strobe.

The result is read in one of two ways. A plain read of the low result address returns the top eight bits. For the full result, software reads the high address first, which returns bits 9..8. The next low-address read then returns bits 7..0.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 0x10, both result addresses read 0x00, `irq` is 0 and `ch_sel` is 0.
- R2: A control write stores bits [2:0] as the channel, driven on `ch_sel`, and bit 3 as the clock select (1 = undivided). On a control read, bit 4 is the completion flag and bits 7..5 read 0.
- R3: Writing a control byte with bit 4 = 0 starts a conversion. From the next cycle, bit 4 reads 0 until the conversion ends.
- R4: Bit 4 reads 1 again exactly 61 system-clock cycles after the starting write edge when clock select is 1, and exactly 122 cycles after it when clock select is 0.
- R5: The finished result equals the 10-bit input level of the selected channel. Each trial bit is kept when the comparator reports input >= trial code and is cleared otherwise.
- R6: Completion sets `irq` to 1. It stays 1 until a cycle with `irq_clr` high clears it.
- R7: A low-address (address 1) read that does not directly follow a high-address read returns result bits 9..2.
- R8: A high-address (address 2) read returns {000000, result[9:8]}. The next low-address read returns result[7:0], and any later low read returns bits 9..2 again.
- R9: Starting a conversion cancels a pending high-address read, so the next low read returns bits 9..2.
- R10: During a conversion the result addresses return the previous result. Reading them does not disturb the conversion.
- R11: A start written while a conversion is running restarts it from the MSB. It then completes in the full cycle count measured from the restarting write, on the newly selected channel.
- R12: A control write with bit 4 = 1 starts nothing: the flag stays 1, `irq` stays 0 and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 result low, 2 result high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; drives the read-order side effect |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_clr | input | 1 | Clears the interrupt request |
| irq | output | 1 | Conversion-complete interrupt request |
| ch_sel | output | 3 | Analog channel number to the input multiplexer |
| dac_code | output | 10 | Trial code to the ladder DAC |
| cmp_in | input | 1 | Comparator: 1 when input >= trial level |

## Verification
The assertions assume that the clock-select bit does not change during a conversion, so the tick spacing stays uniform. They also assume that `cmp_in` is a function of the settled `dac_code` and the selected channel. The bench keeps within both assumptions. Its comparator stub compares a per-channel level with `dac_code` combinationally, and it never rewrites the control register mid-conversion except to start a new conversion. It sweeps every channel in both clock modes with end-of-range and arithmetic input levels, and gives each channel a distinct level so that a wrong channel shows up in the result.

// File: rtl/sar_adc_pkg.sv
// Shared definitions for the converter controller.
// Assumes a byte-wide register bus and a 10-bit result.
package sar_adc_pkg;
    localparam int RES_BITS = 10;
    localparam int BUS_W    = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    localparam int FLAG_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL,
        ST_LATCH
    } sar_state_e;
endpackage

// File: rtl/adc_tick_gen.sv
// Conversion-clock enable generator.
// Gives one tick per system cycle (fast) or one every second cycle (slow)
// while a conversion runs. The phase is reset on each start so that the
// cycle count is fixed. Assumes fast does not change mid-conversion.
module adc_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy,
    input  logic fast,
    output logic tick
);
    logic phase_q;

    // Divide-by-two phase, realigned on every start.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= 1'b0;
        else if (start)  phase_q <= 1'b0;
        else if (busy)   phase_q <= ~phase_q;
    end

    // Enable qualified by mode and phase.
    always_comb tick = busy && !start && (fast || phase_q);

    // R4
    slow_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !fast) |=> !tick);
endmodule

// File: rtl/sar_engine.sv
// Bit-serial approximation sequencer.
// Sequence: SAMPLE_TICKS of sampling, then SETTLE_TICKS per bit from MSB to
// LSB, then LATCH_TICKS before the finish strobe. Advances only on tick.
// A trial bit is kept when cmp_in is 1 at the last settling tick.
module sar_engine #(
    parameter int RES_BITS     = 10,
    parameter int SAMPLE_TICKS = 8,
    parameter int SETTLE_TICKS = 5,
    parameter int LATCH_TICKS  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                tick,
    input  logic                cmp_in,
    output logic                busy,
    output logic                fin,
    output logic [RES_BITS-1:0] code
);
    import sar_adc_pkg::*;

    localparam int MAX_A   = (SAMPLE_TICKS > SETTLE_TICKS) ? SAMPLE_TICKS : SETTLE_TICKS;
    localparam int CNT_MAX = (MAX_A > LATCH_TICKS) ? MAX_A : LATCH_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int TOTAL   = SAMPLE_TICKS + RES_BITS * SETTLE_TICKS + LATCH_TICKS;
    localparam int TOT_W   = $clog2(TOTAL + 1) + 1;
    localparam logic [RES_BITS-1:0] MSB = {1'b1, {(RES_BITS-1){1'b0}}};

    sar_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [RES_BITS-1:0] mask_q;
    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] kept;

    // Trial code after the comparator decision on the current bit.
    always_comb kept = cmp_in ? code_q : (code_q & ~mask_q);

    // Sequencer: phase, in-phase counter, trial mask and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
            code_q  <= '0;
        end else if (start) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
            mask_q  <= '0;
            code_q  <= '0;
        end else if (tick) begin
            case (state_q)
                ST_SAMPLE: begin
                    if (cnt_q == CNT_W'(SAMPLE_TICKS - 1)) begin
                        state_q <= ST_TRIAL;
                        cnt_q   <= '0;
                        mask_q  <= MSB;
                        code_q  <= MSB;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (cnt_q == CNT_W'(SETTLE_TICKS - 1)) begin
                        cnt_q <= '0;
                        if (mask_q[0]) begin
                            state_q <= ST_LATCH;
                            mask_q  <= '0;
                            code_q  <= kept;
                        end else begin
                            mask_q  <= mask_q >> 1;
                            code_q  <= kept | (mask_q >> 1);
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_LATCH: begin
                    if (cnt_q == CNT_W'(LATCH_TICKS - 1)) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs: busy level, finish strobe, DAC code.
    always_comb begin
        busy = (state_q != ST_IDLE);
        fin  = tick && (state_q == ST_LATCH) && (cnt_q == CNT_W'(LATCH_TICKS - 1));
        code = code_q;
    end

    // Checker: ticks seen since the last start.
    logic [TOT_W-1:0] ticks_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)     ticks_seen_q <= '0;
        else if (start) ticks_seen_q <= '0;
        else if (tick)  ticks_seen_q <= ticks_seen_q + 1'b1;
    end

    // R4
    conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (ticks_seen_q == TOT_W'(TOTAL - 1)));
    // R5
    trial_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q));
    // R11
    restart_from_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (code_q == '0 && state_q == ST_SAMPLE));
endmodule

// File: rtl/sar_adc_ctrl.sv
// Converter controller top: control/status register, result register with
// two-step read ordering, interrupt request, and the tick generator and
// approximation engine. Assumes single-cycle bus strobes and combinational
// read data.
module sar_adc_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_clr,
    output logic       irq,
    output logic [2:0] ch_sel,
    output logic [9:0] dac_code,
    input  logic       cmp_in
);
    import sar_adc_pkg::*;

    logic                ctrl_wr;
    logic                start;
    logic                tick;
    logic                busy;
    logic                fin;
    logic [RES_BITS-1:0] code;
    logic [2:0]          ch_q;
    logic                fast_q;
    logic                done_q;
    logic [RES_BITS-1:0] result_q;
    logic                hi_pend_q;
    logic                irq_q;
    logic                unused_wdata;

    // Bus decode for control writes and conversion start.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        start   = ctrl_wr && !bus_wdata[FLAG_BIT];
    end
    assign unused_wdata = ^bus_wdata[7:5];

    adc_tick_gen u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .fast  (fast_q),
        .tick  (tick)
    );

    sar_engine #(.RES_BITS(RES_BITS)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tick   (tick),
        .cmp_in (cmp_in),
        .busy   (busy),
        .fin    (fin),
        .code   (code)
    );

    // Control register: channel, clock select, completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            fast_q <= 1'b0;
            done_q <= 1'b1;
        end else begin
            if (fin) done_q <= 1'b1;
            if (ctrl_wr) begin
                ch_q   <= bus_wdata[2:0];
                fast_q <= bus_wdata[3];
                if (!bus_wdata[FLAG_BIT]) done_q <= 1'b0;
            end
        end
    end

    // Result register, loaded only at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)   result_q <= '0;
        else if (fin) result_q <= code;
    end

    // Read-order flag: set by a high read, used and cleared by a low read.
    always_ff @(posedge clk) begin
        if (!rst_n)                              hi_pend_q <= 1'b0;
        else if (start)                          hi_pend_q <= 1'b0;
        else if (bus_rd && bus_addr == ADDR_HI)  hi_pend_q <= 1'b1;
        else if (bus_rd && bus_addr == ADDR_LO)  hi_pend_q <= 1'b0;
    end

    // Interrupt request: set on completion, held until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (fin)     irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {3'b000, done_q, fast_q, ch_q};
            ADDR_LO:   bus_rdata = hi_pend_q ? result_q[7:0] : result_q[9:2];
            ADDR_HI:   bus_rdata = {6'b000000, result_q[9:8]};
            default:   bus_rdata = 8'h00;
        endcase
    end

    // Outputs.
    always_comb begin
        irq      = irq_q;
        ch_sel   = ch_q;
        dac_code = code;
    end

    // R3
    start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_q);
    // R6
    irq_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> irq_q);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(result_q));
    // R12
    no_start_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[FLAG_BIT] && !busy) |=> (done_q && !busy));
    // R9
    start_drops_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !hi_pend_q);
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_clr = 1'b0;
    logic       irq;
    logic [2:0] ch_sel;
    logic [9:0] dac_code;
    logic       cmp_in;

    logic [9:0] vin [8];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Behavioural analog stub: comparator against the selected channel level.
    always_comb cmp_in = (vin[ch_sel] >= dac_code);

    sar_adc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_clr(irq_clr), .irq(irq), .ch_sel(ch_sel), .dac_code(dac_code),
        .cmp_in(cmp_in)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk);
        bus_addr  = 2'd0;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
        bus_addr = 2'd0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    // Starts a conversion and counts edges after the write edge until done.
    task automatic run_conv(input int ch, input int fast, input int prev, output int n);
        wr_ctrl({3'b000, 1'b0, fast[0], ch[2:0]});
        n = 0;
        while (n < 400) begin
            @(posedge clk);
            #1;
            n++;
            bus_addr = 2'd0;
            #1;
            if (n == 1) chk("R3 flag low during conversion", int'(bus_rdata[4]), 0);
            if (n == 20) begin
                bus_addr = 2'd1;
                #1 chk("R10 previous result during conversion", int'(bus_rdata), prev >> 2);
                bus_addr = 2'd0;
                #1;
            end
            if (bus_rdata[4]) break;
        end
    endtask

    initial begin
        logic [7:0] d;
        int n;
        int prev;
        int exp_n;

        for (int c = 0; c < 8; c++) vin[c] = 10'(c * 97 + 5);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 control reset value", int'(d), 8'h10);
        rd(2'd1, d); chk("R1 low result reset", int'(d), 0);
        rd(2'd2, d); chk("R1 high result reset", int'(d), 0);
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 ch_sel reset", int'(ch_sel), 0);

        // R2 and R12: write with flag bit 1
        wr_ctrl(8'hFF);
        chk("R2 ch_sel follows write", int'(ch_sel), 7);
        rd(2'd0, d); chk("R2 unused bits read 0", int'(d), 8'h1F);
        repeat (130) @(negedge clk);
        rd(2'd0, d); chk("R12 flag stays 1", int'(d), 8'h1F);
        chk("R12 no irq", int'(irq), 0);
        rd(2'd1, d); chk("R12 result unchanged", int'(d), 0);

        // Sweep: patterns x clock modes x channels (R4 R5 R6 R7 R8 R2)
        prev = 0;
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 2; f++) begin
                for (int ch = 0; ch < 8; ch++) begin
                    for (int c = 0; c < 8; c++) vin[c] = 10'(c * 97 + p * 311 + f * 53 + 1);
                    if (p == 0) vin[ch] = 10'd0;
                    if (p == 1) vin[ch] = 10'd1023;
                    run_conv(ch, f, prev, n);
                    exp_n = f ? 61 : 122;
                    chk("R4 conversion length", n, exp_n);
                    chk("R2 ch_sel", int'(ch_sel), ch);
                    chk("R6 irq set", int'(irq), 1);
                    rd(2'd1, d); chk("R7 R5 plain low read", int'(d), int'(vin[ch]) >> 2);
                    rd(2'd2, d); chk("R8 high read", int'(d), int'(vin[ch]) >> 8);
                    rd(2'd1, d); chk("R8 R5 low after high", int'(d), int'(vin[ch]) & 255);
                    rd(2'd1, d); chk("R8 next low back to top bits", int'(d), int'(vin[ch]) >> 2);
                    repeat (4) @(negedge clk);
                    chk("R6 irq held", int'(irq), 1);
                    clear_irq();
                    chk("R6 irq cleared", int'(irq), 0);
                    prev = int'(vin[ch]);
                end
            end
        end

        // R9: pending high read cancelled by a start
        for (int c = 0; c < 8; c++) vin[c] = 10'(c * 61 + 700);
        rd(2'd2, d);
        run_conv(3, 1, prev, n);
        rd(2'd1, d); chk("R9 low read after start", int'(d), int'(vin[3]) >> 2);
        prev = int'(vin[3]);
        clear_irq();

        // R11: restart mid-conversion on a new channel
        wr_ctrl(8'h08);
        repeat (25) @(negedge clk);
        chk("R11 first conversion still running", int'(irq), 0);
        run_conv(5, 1, prev, n);
        chk("R11 length from restart", n, 61);
        rd(2'd2, d); chk("R11 high bits of new channel", int'(d), int'(vin[5]) >> 8);
        rd(2'd1, d); chk("R11 low bits of new channel", int'(d), int'(vin[5]) & 255);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule